// File: doc/BRIEF.md
# Turbo-Code Bit-Grouping Serializer

This block sits between the subblock interleavers of a turbo encoder and the QAM mapper. Six interleaved subblocks of equal length N are written into local buffers through a one-bit write port: two systematic subblocks (A, B) and four parity subblocks (Y1, Y2, W1, W2). A start pulse then latches the subblock length and the modulation order. The block emits the grouped codeword as one serial bit stream of 6N bits. The stream carries A unchanged, then B rotated left by one position, then Y1 and Y2 interleaved bit by bit, then W1 and W2 interleaved bit by bit. The merged W block is rotated left by one position when the FEC block size 2N is a whole multiple of the modulation order.

The rotation amount for W is settled once at the start pulse from the latched length and order. The per-bit path has no divider. The output is a valid/ready stream. A bit is consumed on a rising clock edge where both out_valid and out_ready are high. While out_ready is low, the block holds the presented bit and its last flag and does not advance. It never withdraws out_valid before the handshake. Buffers and configuration are locked while a codeword drains: start pulses and writes arriving while busy is high have no effect.

Top module: `bitgroup_mux`

## Requirements
- R1: After reset, busy and out_valid are low.
- R2: An accepted codeword yields exactly 6N handshaken bits in block order A, B, Y, W. out_last is high on bit 6N-1 only, and busy falls right after that bit's handshake.
- R3: Output bits 0..N-1 are A[0]..A[N-1].
- R4: Output bits N..2N-1 are B[1]..B[N-1] followed by B[0].
- R5: Output bits 2N..4N-1 are Y1[0], Y2[0], Y1[1], Y2[1], ... Y2[N-1].
- R6: When 2N is not a multiple of the order, bits 4N..6N-1 are W1[0], W2[0], W1[1], ... W2[N-1].
- R7: cfg_order holds the numeric order: 2, 4 or 6 (QPSK, 16-QAM, 64-QAM). When 2N is a multiple of it, the merged W block is rotated left by one: W2[0], W1[1], W2[1], ... W2[N-1], W1[0].
- R8: While out_valid is high and out_ready low, out_bit and out_last hold and the stream does not advance.
- R9: A start pulse while busy is high changes neither the running stream nor the latched configuration. A write while busy is high leaves the buffer unchanged, as seen in a later codeword.
- R10: A start pulse in the same cycle as the final handshake is ignored, and busy is low afterwards.
- R11: wr_sel codes are A=0, B=1, Y1=2, Y2=3, W1=4, W2=5. A start with cfg_n of 0 or above MAX_N is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 3 | Subblock select for write |
| wr_addr | input | AW | Bit index within subblock |
| wr_data | input | 1 | Bit to store |
| cfg_n | input | NW | Subblock length N, sampled at start |
| cfg_order | input | 3 | Modulation order, sampled at start |
| start | input | 1 | Begin streaming one codeword |
| busy | output | 1 | Codeword in progress |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream accepts bit |
| out_bit | output | 1 | Serial grouped bit |
| out_last | output | 1 | Final bit of codeword |

## Verification
Two events can fall on one clock edge: the final output handshake, which ends the busy state, and a new start pulse. The bench raises start during exactly that cycle and checks that busy and out_valid are low one cycle later, so the late start is dropped rather than accepted. A second case pairs a mid-stream start pulse with a buffer write in one cycle. The stream must keep its original sequence, and a later replay of the same buffers must show the write did not land. Rotated and unrotated W blocks are judged against a bench model under several lengths, orders and stall patterns.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_Y = 2'd2,
    PH_W = 2'd3
  } phase_t;

  localparam int NUM_SUB = 6;
  localparam logic [2:0] SB_A  = 3'd0;
  localparam logic [2:0] SB_B  = 3'd1;
  localparam logic [2:0] SB_Y1 = 3'd2;
  localparam logic [2:0] SB_Y2 = 3'd3;
  localparam logic [2:0] SB_W1 = 3'd4;
  localparam logic [2:0] SB_W2 = 3'd5;
endpackage

// File: rtl/bg_store.sv
module bg_store #(
  parameter int MAX_N = 608,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic [2:0]    rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  import bg_pkg::*;

  logic [MAX_N-1:0]   sub_q [NUM_SUB];
  logic [NUM_SUB-1:0] tap;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    always_ff @(posedge clk) begin
      if (wr_en && !lock && (wr_sel == 3'(s)) && (int'(wr_addr) < MAX_N))
        sub_q[s][wr_addr] <= wr_data;
    end
    assign tap[s] = (int'(rd_addr) < MAX_N) ? sub_q[s][rd_addr] : 1'b0;
  end

  always_comb begin
    rd_bit = 1'b0;
    for (int s = 0; s < NUM_SUB; s++)
      if (rd_sel == 3'(s)) rd_bit = tap[s];
  end

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (int'(rd_addr) < MAX_N) && (rd_sel < 3'(NUM_SUB))) else $error("rd range"); // R2
endmodule

// File: rtl/bg_kcalc.sv
module bg_kcalc #(
  parameter int NW = 10
) (
  input  logic [NW-1:0] n_in,
  input  logic [2:0]    order_in,
  output logic          k_out
);
  logic [1:0] mod3;

  always_comb begin
    logic [2:0] acc;
    mod3 = 2'd0;
    for (int i = NW - 1; i >= 0; i--) begin
      acc  = {mod3, n_in[i]};
      mod3 = (acc >= 3'd3) ? 2'(acc - 3'd3) : acc[1:0];
    end
  end

  always_comb begin
    case (order_in)
      3'd2:    k_out = 1'b1;
      3'd4:    k_out = ~n_in[0];
      3'd6:    k_out = (mod3 == 2'd0);
      default: k_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/bg_seq.sv
module bg_seq #(
  parameter int MAX_N = 608,
  parameter int AW    = 10,
  parameter int NW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] cfg_n,
  input  logic          k_in,
  input  logic          out_ready,
  output logic          busy,
  output logic [2:0]    rd_sel,
  output logic [AW-1:0] rd_addr,
  output logic          out_last
);
  import bg_pkg::*;

  phase_t        ph_q;
  logic [NW:0]   cnt_q;
  logic [NW-1:0] n_q;
  logic          k_q;
  logic          busy_q;

  logic [NW:0]   n_ext, lim_ab, lim_yw, lim, b_idx;
  logic [NW+1:0] w_m, w_two;
  logic          at_end, advance, accept;

  assign n_ext  = {1'b0, n_q};
  assign lim_ab = n_ext - 1'b1;
  assign lim_yw = {n_q, 1'b0} - 1'b1;
  assign lim    = (ph_q == PH_A || ph_q == PH_B) ? lim_ab : lim_yw;
  assign at_end = (cnt_q == lim);
  assign advance = busy_q && out_ready;
  assign accept  = start && !busy_q && (cfg_n != '0) && (int'(cfg_n) <= MAX_N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_A;
      cnt_q  <= '0;
      n_q    <= '0;
      k_q    <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      ph_q   <= PH_A;
      cnt_q  <= '0;
      n_q    <= cfg_n;
      k_q    <= k_in;
    end else if (advance) begin
      if (at_end) begin
        cnt_q <= '0;
        if (ph_q == PH_W) busy_q <= 1'b0;
        else              ph_q   <= phase_t'(ph_q + 2'd1);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign b_idx = (cnt_q == lim_ab) ? '0 : cnt_q + 1'b1;
  assign w_two = {1'b0, n_q, 1'b0};

  always_comb begin
    w_m = {1'b0, cnt_q} + {{(NW+1){1'b0}}, k_q};
    if (w_m == w_two) w_m = '0;
  end

  always_comb begin
    case (ph_q)
      PH_A: begin rd_sel = SB_A; rd_addr = AW'(cnt_q); end
      PH_B: begin rd_sel = SB_B; rd_addr = AW'(b_idx); end
      PH_Y: begin
        rd_sel  = cnt_q[0] ? SB_Y2 : SB_Y1;
        rd_addr = AW'(cnt_q >> 1);
      end
      default: begin
        rd_sel  = w_m[0] ? SB_W2 : SB_W1;
        rd_addr = AW'(w_m >> 1);
      end
    endcase
  end

  assign busy     = busy_q;
  assign out_last = busy_q && (ph_q == PH_W) && at_end;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !out_ready |=> busy_q && $stable(ph_q) && $stable(cnt_q)) else $error("stall"); // R8
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && (ph_q != $past(ph_q)) |-> (ph_q == phase_t'($past(ph_q) + 2'd1))) else $error("phase"); // R2
  AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && out_last |=> !busy_q) else $error("last"); // R10
  AST_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !(out_ready && out_last) |=> busy_q && $stable(n_q) && $stable(k_q)) else $error("blocked"); // R9
endmodule

// File: rtl/bitgroup_mux.sv
module bitgroup_mux #(
  parameter int MAX_N = 608,
  localparam int AW   = $clog2(MAX_N),
  localparam int NW   = $clog2(MAX_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic [NW-1:0] cfg_n,
  input  logic [2:0]    cfg_order,
  input  logic          start,
  output logic          busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit,
  output logic          out_last
);
  logic          k_w;
  logic [2:0]    rd_sel;
  logic [AW-1:0] rd_addr;
  logic          busy_w;

  bg_kcalc #(.NW(NW)) u_kcalc (
    .n_in    (cfg_n),
    .order_in(cfg_order),
    .k_out   (k_w)
  );

  bg_seq #(.MAX_N(MAX_N), .AW(AW), .NW(NW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_n    (cfg_n),
    .k_in     (k_w),
    .out_ready(out_ready),
    .busy     (busy_w),
    .rd_sel   (rd_sel),
    .rd_addr  (rd_addr),
    .out_last (out_last)
  );

  bg_store #(.MAX_N(MAX_N), .AW(AW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock   (busy_w),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_addr(rd_addr),
    .rd_bit (out_bit)
  );

  assign busy      = busy_w;
  assign out_valid = busy_w;

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last)) else $error("hold"); // R8
endmodule

// File: tb/bitgroup_mux_test.sv
`timescale 1ns/1ps
module bitgroup_mux_test;
  localparam int MAX_N = 608;
  localparam int AW = $clog2(MAX_N);
  localparam int NW = $clog2(MAX_N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [AW-1:0] wr_addr = '0;
  logic wr_data = 1'b0;
  logic [NW-1:0] cfg_n = '0;
  logic [2:0] cfg_order = '0;
  logic start = 1'b0;
  logic out_ready = 1'b0;
  logic busy, out_valid, out_bit, out_last;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit model [6][MAX_N];

  always #2.5 clk = ~clk;

  bitgroup_mux #(.MAX_N(MAX_N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_n(cfg_n), .cfg_order(cfg_order), .start(start),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_last(out_last)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int n, input int seed);
    for (int s = 0; s < 6; s++)
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        model[s][i] = bit'(((i * 7 + s * 3 + seed) ^ (i >> 2) ^ (i * seed >> 3)) & 1);
        wr_en = 1'b1; wr_sel = 3'(s); wr_addr = AW'(i); wr_data = model[s][i];
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit exp_bit(input int n, input int k, input int j);
    int m;
    if (j < n) return model[0][j];
    if (j < 2 * n) return model[1][(j - n + 1) % n];
    if (j < 4 * n) begin
      m = j - 2 * n;
      return model[2 + (m % 2)][m / 2];
    end
    m = (j - 4 * n + k) % (2 * n);
    return model[4 + (m % 2)][m / 2];
  endfunction

  function automatic string req_of(input int n, input int k, input int j);
    if (j < n) return "R3";
    if (j < 2 * n) return "R4";
    if (j < 4 * n) return "R5";
    return (k != 0) ? "R7" : "R6";
  endfunction

  // mode 0: ready always, 1: stall pattern, 2: mid-stream start+write, 3: start on last
  task automatic stream(input int n, input int order, input int mode);
    int k, got, lfsr;
    bit stalled, pb, pl;
    k = ((2 * n) % order == 0) ? 1 : 0;
    @(negedge clk);
    start = 1'b1; cfg_n = NW'(n); cfg_order = 3'(order);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    got = 0; lfsr = 5; stalled = 0; pb = 0; pl = 0;
    while (got < 6 * n) begin
      if (mode == 1) begin
        lfsr = ((lfsr << 1) ^ ((lfsr >> 4) & 1) ^ ((lfsr >> 2) & 1)) & 31;
        out_ready = (lfsr % 3) != 0;
      end else out_ready = 1'b1;
      #1;
      if (stalled) begin
        check(out_bit === pb && out_last === pl, "R8 hold under stall", int'(out_bit), int'(pb));
        stalled = 0;
      end
      check(out_valid === 1'b1, "R2 valid during codeword", int'(out_valid), 1);
      if (out_ready) begin
        check(out_bit === exp_bit(n, k, got), req_of(n, k, got), int'(out_bit), int'(exp_bit(n, k, got)));
        check(out_last === (got == 6 * n - 1), "R2 last flag", int'(out_last), int'(got == 6 * n - 1));
        if (mode == 2 && got == 3) begin
          start = 1'b1; cfg_n = NW'(3); cfg_order = 3'd2;
          wr_en = 1'b1; wr_sel = 3'd0; wr_addr = '0; wr_data = ~model[0][0];
        end
        if (mode == 3 && got == 6 * n - 1) start = 1'b1;
        got++;
      end else begin
        stalled = 1; pb = out_bit; pl = out_last;
      end
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
    end
    out_ready = 1'b0;
    #1;
    check(busy === 1'b0 && out_valid === 1'b0, (mode == 3) ? "R10 start on last ignored" : "R2 idle after last",
          int'(busy), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && out_valid === 1'b0, "R1 reset idle", int'(busy), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_bad_len();
    @(negedge clk);
    start = 1'b1; cfg_n = '0; cfg_order = 3'd4;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b0, "R11 zero length ignored", int'(busy), 0);
  endtask

  task automatic t_order6();
    load(6, 1);  stream(6, 6, 0);
    load(8, 2);  stream(8, 6, 0);
  endtask

  task automatic t_order4();
    load(5, 3);  stream(5, 4, 0);
    load(8, 4);  stream(8, 4, 0);
  endtask

  task automatic t_order2();
    load(5, 5);  stream(5, 2, 0);
  endtask

  task automatic t_stall();
    load(7, 6);  stream(7, 4, 1);
    stream(9 - 2, 6, 1);
  endtask

  task automatic t_busy_block();
    load(6, 7);
    stream(6, 4, 2);   // R9 start and write during busy
    stream(6, 4, 0);   // R9 replay shows buffer untouched
  endtask

  task automatic t_last_start();
    load(4, 8);
    stream(4, 6, 3);   // R10
    stream(4, 6, 0);
  endtask

  task automatic t_large();
    load(480, 9);  stream(480, 6, 0);
    load(608, 10); stream(608, 6, 0);
  endtask

  initial begin
    t_reset();
    t_bad_len();
    t_order6();
    t_order4();
    t_order2();
    t_stall();
    t_busy_block();
    t_last_start();
    t_large();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule